// File: doc/BRIEF.md
# FIFO Status Flag and Service Request Controller

This block tracks the status of a bank of command queues and result queues inside an ADC conversion-queue controller and turns that status into service requests. For each command queue it keeps a fill flag, meaning there is room for another command. For each result queue it keeps a drain flag, meaning a result is waiting. Each result queue also has an overflow flag. Command underflow and trigger-overrun arrive as single-cycle event pulses and are held in flags of their own.

Each fill and drain condition is routed either to an interrupt line or to a DMA request line. A per-queue enable bit and a per-queue mode select bit control the routing. The mode also sets how the flag is retired. In interrupt mode software clears the flag by writing a one. In DMA mode hardware clears it once the queue reaches the state the transfer was working towards.

A write strobe carries write-one-to-clear masks for every flag. The enabled error flags of all queues are combined into a single error interrupt. A result that arrives while its queue is full is discarded, so the entries already stored are kept.

Top module: `fifo_flag_req_ctrl`

## Requirements
- R1: A fill flag becomes 1 one clock after its command queue is seen not full (`cmd_full`=0).
- R2: A drain flag becomes 1 one clock after its result queue is seen non-empty (`res_empty`=0).
- R3: A request output is registered. It goes high one clock after its flag and enable are both 1. The mode bit picks the target: select 0 drives the interrupt output, select 1 drives the DMA output.
- R4: In interrupt mode (select=0), writing a 1 to a fill or drain clear bit with `wr_en` high makes that flag 0 on the next clock. A 0 in the mask leaves the flag unchanged. If the queue condition still holds, the flag returns to 1 on the clock after that.
- R5: In DMA mode (select=1), a fill flag is cleared on the clock after its queue is seen full, and a drain flag is cleared on the clock after its queue is seen empty. Clear-bit writes to these flags are ignored in DMA mode.
- R6: Writing a 1 to a fill clear bit while that queue is in DMA mode sets the sticky `illegal_wr` output on the next clock. `illegal_wr` is cleared by writing `wr_clr_illegal`=1, and a new illegal write in the same cycle wins over the clear.
- R7: `res_store` is high for an arriving result only while its queue is not full. An arrival at a full queue is dropped and sets that queue's overflow flag on the next clock.
- R8: Overflow, underflow and overrun flags are set only by their event, and stay set until a write-one-to-clear. If an event and a clear fall in the same cycle, the flag ends up set.
- R9: `ovf_irq[i]` is high one clock after overflow flag i and its enable `ovf_ie[i]` are both 1.
- R10: `err_irq` is high one clock after any of the 3×N event flags is 1 together with its own enable bit.
- R11: Synchronous active-low reset clears every flag and every request output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_full | input | N | Command queue full level, one bit per queue |
| res_empty | input | N | Result queue empty level |
| res_full | input | N | Result queue full level |
| res_arrive | input | N | Result arriving for a queue (one-cycle strobe) |
| cmd_underflow | input | N | Command underflow event pulse |
| trig_overrun | input | N | Trigger overrun event pulse |
| fill_en | input | N | Fill request enable |
| fill_dma_sel | input | N | Fill request mode, 0 interrupt, 1 DMA |
| drain_en | input | N | Drain request enable |
| drain_dma_sel | input | N | Drain request mode, 0 interrupt, 1 DMA |
| ovf_ie | input | N | Overflow interrupt enable |
| unf_ie | input | N | Underflow interrupt enable |
| ovr_ie | input | N | Overrun interrupt enable |
| wr_en | input | 1 | Clear-write strobe |
| wr_clr_fill | input | N | Write-one-to-clear mask for fill flags |
| wr_clr_drain | input | N | Write-one-to-clear mask for drain flags |
| wr_clr_ovf | input | N | Write-one-to-clear mask for overflow flags |
| wr_clr_unf | input | N | Write-one-to-clear mask for underflow flags |
| wr_clr_ovr | input | N | Write-one-to-clear mask for overrun flags |
| wr_clr_illegal | input | 1 | Write-one-to-clear for the illegal-write bit |
| fill_flag | output | N | Fill flags |
| drain_flag | output | N | Drain flags |
| ovf_flag | output | N | Overflow flags |
| unf_flag | output | N | Underflow flags |
| ovr_flag | output | N | Overrun flags |
| res_store | output | N | Arriving result may be written into its queue |
| fill_irq | output | N | Fill interrupt requests |
| fill_dma | output | N | Fill DMA requests |
| drain_irq | output | N | Drain interrupt requests |
| drain_dma | output | N | Drain DMA requests |
| ovf_irq | output | N | Per-queue overflow interrupts |
| err_irq | output | 1 | Combined error interrupt |
| illegal_wr | output | 1 | Sticky illegal fill-clear-in-DMA-mode indicator |

## Verification
The bench uses the default of six queues. At that size the combined interrupt must merge eighteen independent flag and enable pairs, and the bench flips modes and enables per queue, so neighbouring queues run in interrupt and DMA mode at the same time. A fixed seed drives random full and empty levels, event pulses and clear masks, which reaches set-versus-clear collisions in every flag type. Directed cases pin down the DMA-mode illegal write, an event arriving together with its clear, and the one-cycle dip of a level flag after a software clear.

// File: rtl/ffrc_pkg.sv
// Shared definitions for the FIFO flag and request controller.
// Assumes: one mode bit per queue, 0 = interrupt routing, 1 = DMA routing.
package ffrc_pkg;
    typedef enum logic {
        MODE_IRQ = 1'b0,
        MODE_DMA = 1'b1
    } req_mode_e;

    localparam int DEF_QUEUES = 6;
    localparam int EVT_KINDS  = 3;
endpackage

// File: rtl/ffrc_level_flags.sv
// Level-driven status flags (fill or drain), one per queue.
// A flag is raised whenever its level condition holds. A software clear
// (interrupt mode) or a hardware clear (DMA mode, queue reached the done
// state) forces it low for one cycle; it then re-arms from the level.
// Assumes cond_set and cond_done are complementary levels of one queue.
module ffrc_level_flags
    import ffrc_pkg::*;
#(
    parameter int NQ = DEF_QUEUES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] cond_set,
    input  logic [NQ-1:0] cond_done,
    input  logic [NQ-1:0] mode_sel,
    input  logic [NQ-1:0] clr_req,
    output logic [NQ-1:0] flag_q
);
    for (genvar g = 0; g < NQ; g++) begin : g_flag
        logic sw_clr;
        logic hw_clr;
        logic flag_d;

        // Decide the next flag value from the clear sources and the level.
        always_comb begin
            sw_clr = clr_req[g] && (mode_sel[g] == MODE_IRQ);
            hw_clr = cond_done[g] && (mode_sel[g] == MODE_DMA);
            if (sw_clr || hw_clr) flag_d = 1'b0;
            else                  flag_d = flag_q[g] | cond_set[g];
        end

        // Hold the flag state.
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[g] <= 1'b0;
            else        flag_q[g] <= flag_d;
        end

        // R1 / R2: level present and no clear -> flag set next cycle
        p_level_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (cond_set[g] && !(clr_req[g] && !mode_sel[g])) |=> flag_q[g]);
        // R4: interrupt-mode write-one-to-clear
        p_sw_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_sel[g] && clr_req[g]) |=> !flag_q[g]);
        // R5: DMA-mode hardware clear
        p_dma_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_sel[g] && cond_done[g]) |=> !flag_q[g]);
        // R5: DMA-mode software clear has no effect
        p_dma_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_sel[g] && clr_req[g] && !cond_done[g] && flag_q[g]) |=> flag_q[g]);
    end
endmodule

// File: rtl/ffrc_event_flags.sv
// Sticky event flags, one per queue, set by a one-cycle pulse and
// cleared by write-one-to-clear. A pulse in the same cycle as a clear
// leaves the flag set.
// Assumes event inputs are synchronous one-cycle pulses.
module ffrc_event_flags #(
    parameter int NQ = ffrc_pkg::DEF_QUEUES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] evt,
    input  logic [NQ-1:0] clr_req,
    output logic [NQ-1:0] flag_q
);
    logic [NQ-1:0] flag_d;

    // Set has priority over clear.
    always_comb flag_d = evt | (flag_q & ~clr_req);

    // Hold the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    for (genvar g = 0; g < NQ; g++) begin : g_chk
        // R8: event sets the flag even with a clear in the same cycle
        p_evt_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> flag_q[g]);
        // R8: a clear without an event drops the flag
        p_evt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_req[g] && !evt[g]) |=> !flag_q[g]);
        // R8: flag holds without a clear
        p_evt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && !clr_req[g]) |=> flag_q[g]);
    end
endmodule

// File: rtl/ffrc_req_router.sv
// Routes an enabled flag to a registered interrupt or DMA request,
// according to the per-queue mode bit.
// Assumes flag, enable and mode are sampled in the same cycle.
module ffrc_req_router
    import ffrc_pkg::*;
#(
    parameter int NQ = DEF_QUEUES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] flag,
    input  logic [NQ-1:0] enable,
    input  logic [NQ-1:0] mode_sel,
    output logic [NQ-1:0] irq_q,
    output logic [NQ-1:0] dma_q
);
    for (genvar g = 0; g < NQ; g++) begin : g_route
        logic active;

        // A request is wanted when the flag and its enable are both high.
        always_comb active = flag[g] & enable[g];

        // Register the request onto the selected target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                irq_q[g] <= 1'b0;
                dma_q[g] <= 1'b0;
            end else begin
                irq_q[g] <= active && (mode_sel[g] == MODE_IRQ);
                dma_q[g] <= active && (mode_sel[g] == MODE_DMA);
            end
        end

        // R3: enabled flag in interrupt mode -> interrupt next cycle
        p_route_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && enable[g] && !mode_sel[g]) |=> (irq_q[g] && !dma_q[g]));
        // R3: enabled flag in DMA mode -> DMA request next cycle
        p_route_dma_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && enable[g] && mode_sel[g]) |=> (dma_q[g] && !irq_q[g]));
        // R3: no request without the flag and its enable
        p_route_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !(flag[g] && enable[g]) |=> !(irq_q[g] || dma_q[g]));
    end
endmodule

// File: rtl/fifo_flag_req_ctrl.sv
// FIFO status flag and service request controller (top).
// Keeps fill, drain, overflow, underflow and overrun flags for NQ
// command/result queue pairs, routes fill and drain to interrupt or
// DMA lines, builds per-queue overflow and a combined error interrupt,
// and flags illegal fill clears issued in DMA mode.
// Assumes all inputs are synchronous to clk; event inputs are pulses.
module fifo_flag_req_ctrl
    import ffrc_pkg::*;
#(
    parameter int NQ = DEF_QUEUES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] cmd_full,
    input  logic [NQ-1:0] res_empty,
    input  logic [NQ-1:0] res_full,
    input  logic [NQ-1:0] res_arrive,
    input  logic [NQ-1:0] cmd_underflow,
    input  logic [NQ-1:0] trig_overrun,
    input  logic [NQ-1:0] fill_en,
    input  logic [NQ-1:0] fill_dma_sel,
    input  logic [NQ-1:0] drain_en,
    input  logic [NQ-1:0] drain_dma_sel,
    input  logic [NQ-1:0] ovf_ie,
    input  logic [NQ-1:0] unf_ie,
    input  logic [NQ-1:0] ovr_ie,
    input  logic          wr_en,
    input  logic [NQ-1:0] wr_clr_fill,
    input  logic [NQ-1:0] wr_clr_drain,
    input  logic [NQ-1:0] wr_clr_ovf,
    input  logic [NQ-1:0] wr_clr_unf,
    input  logic [NQ-1:0] wr_clr_ovr,
    input  logic          wr_clr_illegal,
    output logic [NQ-1:0] fill_flag,
    output logic [NQ-1:0] drain_flag,
    output logic [NQ-1:0] ovf_flag,
    output logic [NQ-1:0] unf_flag,
    output logic [NQ-1:0] ovr_flag,
    output logic [NQ-1:0] res_store,
    output logic [NQ-1:0] fill_irq,
    output logic [NQ-1:0] fill_dma,
    output logic [NQ-1:0] drain_irq,
    output logic [NQ-1:0] drain_dma,
    output logic [NQ-1:0] ovf_irq,
    output logic          err_irq,
    output logic          illegal_wr
);
    localparam int NEVT = EVT_KINDS * NQ;

    logic [NQ-1:0]   clr_fill_m, clr_drain_m, clr_ovf_m, clr_unf_m, clr_ovr_m;
    logic [NQ-1:0]   ovf_evt;
    logic [NEVT-1:0] evt_flags, evt_enables;
    logic            illegal_set, illegal_clr, illegal_d;
    logic            err_d;
    logic [NQ-1:0]   ovf_irq_d;

    // Qualify every clear mask with the write strobe.
    always_comb begin
        clr_fill_m  = wr_en ? wr_clr_fill  : '0;
        clr_drain_m = wr_en ? wr_clr_drain : '0;
        clr_ovf_m   = wr_en ? wr_clr_ovf   : '0;
        clr_unf_m   = wr_en ? wr_clr_unf   : '0;
        clr_ovr_m   = wr_en ? wr_clr_ovr   : '0;
    end

    // Drop arrivals at a full result queue and turn them into overflow events.
    always_comb begin
        res_store = res_arrive & ~res_full;
        ovf_evt   = res_arrive & res_full;
    end

    ffrc_level_flags #(.NQ(NQ)) u_fill (
        .clk(clk), .rst_n(rst_n),
        .cond_set(~cmd_full), .cond_done(cmd_full),
        .mode_sel(fill_dma_sel), .clr_req(clr_fill_m),
        .flag_q(fill_flag)
    );

    ffrc_level_flags #(.NQ(NQ)) u_drain (
        .clk(clk), .rst_n(rst_n),
        .cond_set(~res_empty), .cond_done(res_empty),
        .mode_sel(drain_dma_sel), .clr_req(clr_drain_m),
        .flag_q(drain_flag)
    );

    ffrc_event_flags #(.NQ(NQ)) u_ovf (
        .clk(clk), .rst_n(rst_n), .evt(ovf_evt), .clr_req(clr_ovf_m), .flag_q(ovf_flag)
    );

    ffrc_event_flags #(.NQ(NQ)) u_unf (
        .clk(clk), .rst_n(rst_n), .evt(cmd_underflow), .clr_req(clr_unf_m), .flag_q(unf_flag)
    );

    ffrc_event_flags #(.NQ(NQ)) u_ovr (
        .clk(clk), .rst_n(rst_n), .evt(trig_overrun), .clr_req(clr_ovr_m), .flag_q(ovr_flag)
    );

    ffrc_req_router #(.NQ(NQ)) u_fill_rt (
        .clk(clk), .rst_n(rst_n), .flag(fill_flag), .enable(fill_en),
        .mode_sel(fill_dma_sel), .irq_q(fill_irq), .dma_q(fill_dma)
    );

    ffrc_req_router #(.NQ(NQ)) u_drain_rt (
        .clk(clk), .rst_n(rst_n), .flag(drain_flag), .enable(drain_en),
        .mode_sel(drain_dma_sel), .irq_q(drain_irq), .dma_q(drain_dma)
    );

    // Gather the error flags and their enables into one vector.
    always_comb begin
        evt_flags   = {ovr_flag, unf_flag, ovf_flag};
        evt_enables = {ovr_ie, unf_ie, ovf_ie};
        err_d       = |(evt_flags & evt_enables);
        ovf_irq_d   = ovf_flag & ovf_ie;
    end

    // Register the overflow and combined error interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_irq <= '0;
            err_irq <= 1'b0;
        end else begin
            ovf_irq <= ovf_irq_d;
            err_irq <= err_d;
        end
    end

    // Work out the next sticky illegal-write state; a new violation beats the clear.
    always_comb begin
        illegal_set = |(clr_fill_m & fill_dma_sel);
        illegal_clr = wr_en & wr_clr_illegal;
        illegal_d   = illegal_set | (illegal_wr & ~illegal_clr);
    end

    // Hold the sticky illegal-write bit.
    always_ff @(posedge clk) begin
        if (!rst_n) illegal_wr <= 1'b0;
        else        illegal_wr <= illegal_d;
    end

    // R6: a fill clear in DMA mode raises the illegal bit
    p_illegal_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && |(wr_clr_fill & fill_dma_sel)) |=> illegal_wr);
    // R6: the illegal bit is sticky until cleared
    p_illegal_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal_wr && !(wr_en && wr_clr_illegal)) |=> illegal_wr);
    // R7: full queue drops arrivals and records overflow
    p_drop_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(res_arrive & res_full)) |=> (|ovf_flag));
    // R9: per-queue overflow interrupt follows flag and enable
    p_ovf_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ovf_flag & ovf_ie)) |=> (|ovf_irq));
    // R10: any enabled error flag reaches the combined interrupt
    p_err_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|({ovr_flag, unf_flag, ovf_flag} & {ovr_ie, unf_ie, ovf_ie})) |=> err_irq);
    // R10: no enabled error flag, no combined interrupt
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|({ovr_flag, unf_flag, ovf_flag} & {ovr_ie, unf_ie, ovf_ie})) |=> !err_irq);
endmodule

// File: tb/fifo_flag_req_ctrl_tb.sv
// Self-checking bench: fixed-seed random stimulus plus directed corners,
// compared every cycle against a model built from the requirements.
module fifo_flag_req_ctrl_tb;
    localparam int N = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] cmd_full, res_empty, res_full, res_arrive, cmd_underflow, trig_overrun;
    logic [N-1:0] fill_en, fill_dma_sel, drain_en, drain_dma_sel, ovf_ie, unf_ie, ovr_ie;
    logic         wr_en, wr_clr_illegal;
    logic [N-1:0] wr_clr_fill, wr_clr_drain, wr_clr_ovf, wr_clr_unf, wr_clr_ovr;
    logic [N-1:0] fill_flag, drain_flag, ovf_flag, unf_flag, ovr_flag, res_store;
    logic [N-1:0] fill_irq, fill_dma, drain_irq, drain_dma, ovf_irq;
    logic         err_irq, illegal_wr;

    int checks = 0;
    int fails  = 0;
    bit started = 0;
    bit done = 0;

    // model state
    logic [N-1:0] m_fill, m_drain, m_ovf, m_unf, m_ovr;
    logic [N-1:0] m_fill_irq, m_fill_dma, m_drain_irq, m_drain_dma, m_ovf_irq;
    logic         m_err, m_ill;

    always #5 clk = ~clk;

    fifo_flag_req_ctrl #(.NQ(N)) u_dut (.*);

    // R4/R5: level flag next value
    function automatic logic [N-1:0] lvl_next(input logic [N-1:0] f, input logic [N-1:0] lvl_full,
                                              input logic [N-1:0] dma, input logic [N-1:0] clr);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if ((clr[i] && !dma[i]) || (lvl_full[i] && dma[i])) r[i] = 1'b0;
            else r[i] = f[i] | ~lvl_full[i];
        end
        return r;
    endfunction

    // R8: event flag next value, set wins
    function automatic logic [N-1:0] evt_next(input logic [N-1:0] f, input logic [N-1:0] e,
                                              input logic [N-1:0] clr);
        return e | (f & ~clr);
    endfunction

    task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Model update and comparison, after each rising edge.
    always @(posedge clk) begin
        logic [N-1:0] cf, cd;
        #2;
        if (!rst_n) begin
            {m_fill, m_drain, m_ovf, m_unf, m_ovr} = '0;
            {m_fill_irq, m_fill_dma, m_drain_irq, m_drain_dma, m_ovf_irq} = '0;
            m_err = 0; m_ill = 0;
        end else begin
            m_fill_irq  = m_fill & fill_en & ~fill_dma_sel;
            m_fill_dma  = m_fill & fill_en & fill_dma_sel;
            m_drain_irq = m_drain & drain_en & ~drain_dma_sel;
            m_drain_dma = m_drain & drain_en & drain_dma_sel;
            m_ovf_irq   = m_ovf & ovf_ie;
            m_err       = |((m_ovf & ovf_ie) | (m_unf & unf_ie) | (m_ovr & ovr_ie));
            cf = wr_en ? wr_clr_fill : '0;
            cd = wr_en ? wr_clr_drain : '0;
            m_ill   = (|(cf & fill_dma_sel)) | (m_ill & ~(wr_en & wr_clr_illegal));
            m_fill  = lvl_next(m_fill, cmd_full, fill_dma_sel, cf);
            m_drain = lvl_next(m_drain, res_empty, drain_dma_sel, cd);
            m_ovf   = evt_next(m_ovf, res_arrive & res_full, wr_en ? wr_clr_ovf : '0);
            m_unf   = evt_next(m_unf, cmd_underflow, wr_en ? wr_clr_unf : '0);
            m_ovr   = evt_next(m_ovr, trig_overrun, wr_en ? wr_clr_ovr : '0);
        end
        started = 1;
        if (!done) begin
            chk(fill_flag, m_fill, "R1/R4/R5 fill_flag");
            chk(drain_flag, m_drain, "R2/R4/R5 drain_flag");
            chk(ovf_flag, m_ovf, "R7/R8 ovf_flag");
            chk(unf_flag, m_unf, "R8 unf_flag");
            chk(ovr_flag, m_ovr, "R8 ovr_flag");
            chk(res_store, res_arrive & ~res_full, "R7 res_store");
            chk(fill_irq, m_fill_irq, "R3 fill_irq");
            chk(fill_dma, m_fill_dma, "R3 fill_dma");
            chk(drain_irq, m_drain_irq, "R3 drain_irq");
            chk(drain_dma, m_drain_dma, "R3 drain_dma");
            chk(ovf_irq, m_ovf_irq, "R9 ovf_irq");
            chk({{(N-1){1'b0}}, err_irq}, {{(N-1){1'b0}}, m_err}, "R10 err_irq");
            chk({{(N-1){1'b0}}, illegal_wr}, {{(N-1){1'b0}}, m_ill}, "R6 illegal_wr");
        end
    end

    task automatic idle();
        cmd_full = '1; res_empty = '1; res_full = '0; res_arrive = '0;
        cmd_underflow = '0; trig_overrun = '0;
        wr_en = 0; wr_clr_illegal = 0;
        wr_clr_fill = '0; wr_clr_drain = '0; wr_clr_ovf = '0; wr_clr_unf = '0; wr_clr_ovr = '0;
    endtask

    task automatic rand_cfg();
        fill_en = N'($urandom); fill_dma_sel = N'($urandom);
        drain_en = N'($urandom); drain_dma_sel = N'($urandom);
        ovf_ie = N'($urandom); unf_ie = N'($urandom); ovr_ie = N'($urandom);
    endtask

    function automatic logic [N-1:0] sparse(input int pct);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (($urandom % 100) < pct);
        return v;
    endfunction

    task automatic rand_in();
        cmd_full = sparse(40); res_empty = sparse(40); res_full = sparse(30);
        res_arrive = sparse(25); cmd_underflow = sparse(5); trig_overrun = sparse(5);
        wr_en = (($urandom % 100) < 30);
        wr_clr_fill = sparse(20); wr_clr_drain = sparse(20); wr_clr_ovf = sparse(30);
        wr_clr_unf = sparse(30); wr_clr_ovr = sparse(30); wr_clr_illegal = (($urandom % 4) == 0);
    endtask

    task automatic final_report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1;
        final_report();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        fill_en = '1; fill_dma_sel = '0; drain_en = '1; drain_dma_sel = '0;
        ovf_ie = '1; unf_ie = '1; ovr_ie = '1;
        repeat (3) @(negedge clk);
        // R11: all cleared after reset
        chk({fill_flag, drain_flag, ovf_flag, unf_flag, ovr_flag}, '0, "R11 flags");
        chk({fill_irq, fill_dma, drain_irq, drain_dma, ovf_irq}, '0, "R11 requests");
        chk({{(N-1){1'b0}}, err_irq | illegal_wr}, '0, "R11 err/illegal");
        rst_n = 1;

        // R4: interrupt-mode clear dips the level flag for one cycle
        cmd_full = '0;
        repeat (3) @(negedge clk);
        wr_en = 1; wr_clr_fill = N'(2);
        @(negedge clk);
        wr_en = 0; wr_clr_fill = '0;
        chk(fill_flag & N'(2), '0, "R4 fill cleared");
        @(negedge clk);
        chk(fill_flag & N'(2), N'(2), "R4 fill re-set");

        // R6: fill clear in DMA mode is ignored and flags illegal
        fill_dma_sel = '1;
        @(negedge clk);
        wr_en = 1; wr_clr_fill = '1;
        @(negedge clk);
        wr_en = 0; wr_clr_fill = '0;
        chk({{(N-1){1'b0}}, illegal_wr}, N'(1), "R6 illegal set");
        chk(fill_flag, '1, "R5 DMA write ignored");

        // R5: DMA-mode fill cleared once queue full
        cmd_full = '1;
        @(negedge clk);
        chk(fill_flag, '0, "R5 DMA hw clear");

        // R8: overflow event and clear in the same cycle keeps the flag
        res_full = N'(1); res_arrive = N'(1); wr_en = 1; wr_clr_ovf = N'(1);
        @(negedge clk);
        idle();
        chk(ovf_flag & N'(1), N'(1), "R8 set wins");
        @(negedge clk);

        // Random phase
        for (int c = 0; c < 3000; c++) begin
            if ((c % 50) == 0) rand_cfg();
            rand_in();
            @(negedge clk);
        end
        idle();
        @(negedge clk);
        @(negedge clk);
        done = 1;
        final_report();
    end
endmodule